// File: doc/BRIEF.md
# Splittable Event Counter Bank

A bank of four physical event counters reached through a 64-bit register bus. Each physical counter runs either as one 32-bit counter or as two independent 16-bit halves. Together they form eight logical counters. A per-counter size bit in the control register picks the mode. Each bus register holds 32 bits in the upper half of the bus word.

Counter writes from software do not touch the live counters. They go to a holding latch, and a pending bit marks the latch as newer than the live value. Every pending latch is copied into its live counter when the control register is written with the enable bit set. This includes a rewrite while the unit is already running. While the unit is enabled, the event inputs advance the counters. A counter or half that wraps to zero raises a status bit. The interrupt output is raised by status bits that the interrupt mask lets through. Reading the status register returns the pending bits and clears them.

Top module: `split_ctr_bank`

## Requirements
- R1: Reset clears all live counters, latches, pending bits, control, status and mask. `irq` is low after reset.
- R2: The 32-bit register value sits in bus bits 63:32. Bus bits 31:0 are ignored on write and read as zero.
- R3: Address map: logical counters 0–7 at addresses 0–7, control at 8, status and mask at 9. Other addresses read zero.
- R4: Control layout: bus bit 63 is the enable bit. Bus bit 32+i sets 16-bit mode for physical counter i. With the unit enabled and counter i in 32-bit mode, `evt[i]` adds one to the whole counter. When the counter wraps from all ones to zero, status bit i is set.
- R5: In 16-bit mode, logical counter i (i<4) is bits 31:16 of physical counter i and counts `evt[i]`. Logical counter i+4 is bits 15:0 and counts `evt[i+4]`. No carry passes between the halves. Their wraps set status bits i and i+4.
- R6: A counter write updates only the latch and sets the pending bit. While the pending bit is set, a counter read returns the latch, and the live counter goes on counting.
- R7: A control write with the enable bit set copies every pending latch into its live counter and clears all pending bits. This holds even if the unit was already enabled.
- R8: While the enable bit is clear, all counters hold their values.
- R9: A read of address 9 returns the status bits and clears them at that clock edge. A wrap in the same cycle stays set.
- R10: A write to address 9 loads the interrupt mask from bus bits 39:32. `irq` is high exactly when some status bit and its mask bit are both set. A zero mask silences `irq` and leaves the status bits in place.
- R11: A write to a logical counter in 16-bit mode replaces only its half. The other half keeps its current value: the latch if the pending bit is set, otherwise the live counter.
- R12: When physical counter i is in 32-bit mode, logical counter i+4 reads and writes the whole physical counter i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data; value in bits 63:32 |
| evt | input | 8 | Event pulses, one per logical counter |
| rdata | output | 64 | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the block with its fixed configuration: four physical counters of 32 bits. Preloading values just below the wrap point makes both the 32-bit wrap and the two 16-bit wraps reachable within a few event pulses. It also shows that no carry crosses between halves. Counter writes made while counting is running show the latch hiding the live value until the next control write.

// File: rtl/split_ctr_bank.sv
module split_ctr_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [63:0] wdata,
  input  logic [7:0]  evt,
  output logic [63:0] rdata,
  output logic        irq
);
  localparam int NPH = 4;
  localparam int CW  = 32;
  localparam int HW  = CW / 2;
  localparam logic [3:0] A_CTL = 4'd8;
  localparam logic [3:0] A_STS = 4'd9;

  logic [NPH-1:0][CW-1:0] live_q, lat_q, vis;
  logic [NPH-1:0]         pend_q, size_q;
  logic                   en_q;
  logic [2*NPH-1:0]       sts_q, msk_q, wrap;

  logic [CW-1:0] wd, mrg, ctr_rd;
  logic [1:0]    idx;
  logic          hi, wr_ctr, wr_ctl, wr_sts, rd_sts, commit;

  assign wd     = wdata[63:32];
  assign idx    = addr[1:0];
  assign hi     = ~addr[2];
  assign wr_ctr = wr_en && !addr[3];
  assign wr_ctl = wr_en && addr == A_CTL;
  assign wr_sts = wr_en && addr == A_STS;
  assign rd_sts = rd_en && addr == A_STS;
  assign commit = wr_ctl && wdata[63];

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_ph
      assign vis[g] = pend_q[g] ? lat_q[g] : live_q[g];
      assign wrap[g] = en_q && evt[g] && !(commit && pend_q[g]) &&
                       (size_q[g] ? live_q[g][CW-1:HW] == '1 : live_q[g] == '1);
      assign wrap[g+NPH] = en_q && evt[g+NPH] && size_q[g] &&
                           !(commit && pend_q[g]) && live_q[g][HW-1:0] == '1;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live_q[g] <= '0;
          lat_q[g]  <= '0;
          pend_q[g] <= 1'b0;
        end else begin
          if (commit && pend_q[g])
            live_q[g] <= lat_q[g];
          else if (en_q && size_q[g]) begin
            live_q[g][CW-1:HW] <= live_q[g][CW-1:HW] + HW'(evt[g]);
            live_q[g][HW-1:0]  <= live_q[g][HW-1:0] + HW'(evt[g+NPH]);
          end else if (en_q)
            live_q[g] <= live_q[g] + CW'(evt[g]);

          if (wr_ctr && idx == g) begin
            lat_q[g]  <= mrg;
            pend_q[g] <= 1'b1;
          end else if (commit)
            pend_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    mrg = wd;
    if (size_q[idx])
      mrg = hi ? {wd[HW-1:0], vis[idx][HW-1:0]} : {vis[idx][CW-1:HW], wd[HW-1:0]};
    ctr_rd = vis[idx];
    if (size_q[idx])
      ctr_rd = hi ? {{HW{1'b0}}, vis[idx][CW-1:HW]} : {{HW{1'b0}}, vis[idx][HW-1:0]};
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (!addr[3])            rdata[63:32] = ctr_rd;
      else if (addr == A_CTL)  rdata[63:32] = {en_q, {(CW-1-NPH){1'b0}}, size_q};
      else if (addr == A_STS)  rdata[63:32] = {{(CW-2*NPH){1'b0}}, sts_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      size_q <= '0;
      sts_q  <= '0;
      msk_q  <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= wdata[63];
        size_q <= wdata[32 +: NPH];
      end
      if (wr_sts) msk_q <= wdata[32 +: 2*NPH];
      sts_q <= (rd_sts ? '0 : sts_q) | wrap;
    end
  end

  assign irq = |(sts_q & msk_q);
endmodule

module split_ctr_bank_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [3:0]        addr,
  input logic [63:0]       wdata,
  input logic [7:0]        evt,
  input logic [63:0]       rdata,
  input logic              irq,
  input logic [3:0][31:0]  live_q,
  input logic [3:0]        pend_q,
  input logic [7:0]        sts_q,
  input logic              en_q
);
  // R2: lower half of read data always zero
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rdata[31:0] == 32'h0);

  // R8: frozen while disabled and no commit
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(wr_en && addr == 4'd8 && wdata[63])) |=> $stable(live_q));

  // R6: counter write marks its latch pending
  a_r6_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr[3]) |=> pend_q[$past(addr[1:0])]);

  // R7: commit clears every pending bit
  a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd8 && wdata[63]) |=> pend_q == 4'h0);

  // R9: status read clears when no event arrives
  a_r9_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd9 && evt == 8'h0) |=> sts_q == 8'h0);

  // R10: zero mask silences the interrupt
  a_r10_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd9 && wdata[39:32] == 8'h0) |=> !irq);
endmodule

bind split_ctr_bank split_ctr_bank_chk i_chk (
  .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .evt, .rdata, .irq,
  .live_q, .pend_q, .sts_q, .en_q
);

// File: tb/test_split_ctr_bank.sv
module test_split_ctr_bank;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  evt = '0;
  logic [63:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  split_ctr_bank i_split_ctr_bank (.clk, .rst_n, .wr_en, .rd_en, .addr,
                                   .wdata, .evt, .rdata, .irq);

  always #10ns clk = ~clk;

  // {tag, is_read, addr, data}
  localparam int NV = 18;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1,  1'b1, 4'h0, 32'h0000_0000},  // R1
    {4'd1,  1'b1, 4'h8, 32'h0000_0000},  // R1
    {4'd6,  1'b0, 4'h0, 32'h1234_5678},  // R6
    {4'd6,  1'b1, 4'h0, 32'h1234_5678},  // R6
    {4'd7,  1'b0, 4'h8, 32'h8000_0000},  // R7
    {4'd7,  1'b1, 4'h0, 32'h1234_5678},  // R7
    {4'd11, 1'b0, 4'h8, 32'h8000_0002},  // R11
    {4'd11, 1'b0, 4'h1, 32'h0000_AAAA},  // R11
    {4'd11, 1'b1, 4'h1, 32'h0000_AAAA},  // R11
    {4'd11, 1'b0, 4'h5, 32'h0000_5555},  // R11
    {4'd11, 1'b1, 4'h5, 32'h0000_5555},  // R11
    {4'd7,  1'b0, 4'h8, 32'h8000_0002},  // R7
    {4'd5,  1'b1, 4'h1, 32'h0000_AAAA},  // R5
    {4'd5,  1'b1, 4'h5, 32'h0000_5555},  // R5
    {4'd12, 1'b0, 4'h8, 32'h0000_0000},  // R12
    {4'd12, 1'b1, 4'h5, 32'hAAAA_5555},  // R12
    {4'd3,  1'b1, 4'hA, 32'h0000_0000},  // R3
    {4'd2,  1'b1, 4'h8, 32'h0000_0000}   // R2
  };

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = {d, 32'hDEAD_BEEF};
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(string r, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1ns check(r, rdata, {exp, 32'h0});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m, int n);
    @(negedge clk);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", {63'h0, irq}, 64'h0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36])
        bus_rd($sformatf("R%0d", VEC[i][40:37]), VEC[i][35:32], VEC[i][31:0]);
      else
        bus_wr(VEC[i][35:32], VEC[i][31:0]);
    end

    // R8: events while disabled
    pulse(8'hFF, 3);
    bus_rd("R8", 4'h0, 32'h1234_5678);

    // R4: 32-bit wrap
    bus_wr(4'h2, 32'hFFFF_FFFE);
    bus_wr(4'h8, 32'h8000_0000);
    bus_wr(4'h9, 32'h0000_0004);
    pulse(8'h04, 2);
    bus_rd("R4", 4'h2, 32'h0);
    check("R10", {63'h0, irq}, 64'h1);
    bus_rd("R9", 4'h9, 32'h0000_0004);
    bus_rd("R9", 4'h9, 32'h0);
    check("R10", {63'h0, irq}, 64'h0);

    // R5: independent halves
    bus_wr(4'h8, 32'h8000_0008);
    bus_wr(4'h3, 32'h0000_FFFF);
    bus_wr(4'h7, 32'h0000_FFFF);
    bus_wr(4'h8, 32'h8000_0008);
    pulse(8'h08, 1);
    bus_rd("R5", 4'h7, 32'h0000_FFFF);
    bus_rd("R5", 4'h3, 32'h0);
    pulse(8'h80, 1);
    bus_rd("R5", 4'h3, 32'h0);
    check("R10", {63'h0, irq}, 64'h0);
    bus_rd("R5", 4'h9, 32'h0000_0088);

    // R10: mask gating and zero mask
    bus_wr(4'h7, 32'h0000_FFFF);
    bus_wr(4'h8, 32'h8000_0008);
    bus_wr(4'h9, 32'h0000_00FF);
    pulse(8'h80, 1);
    check("R10", {63'h0, irq}, 64'h1);
    bus_wr(4'h9, 32'h0);
    check("R10", {63'h0, irq}, 64'h0);
    bus_rd("R10", 4'h9, 32'h0000_0080);

    // R6: latch hides live counting until recommit (R7)
    bus_wr(4'h0, 32'h0000_0011);
    pulse(8'h01, 2);
    bus_rd("R6", 4'h0, 32'h0000_0011);
    bus_wr(4'h8, 32'h8000_0008);
    bus_rd("R7", 4'h0, 32'h0000_0011);
    pulse(8'h01, 1);
    bus_rd("R4", 4'h0, 32'h0000_0012);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_rd("R1", 4'h2, 32'h0);
    bus_rd("R1", 4'h9, 32'h0);
    check("R1", {63'h0, irq}, 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule